// File: doc/BRIEF.md
# Cascaded Serial Codec Port Node

This block is the serial-port logic of one node in a daisy chain of converter nodes. Each node takes 16-bit words on a serial input framed by an input frame sync, and shifts 16-bit words out on a serial output framed by an output frame sync. The output sync of one node feeds the input sync of the next, and a sample-event strobe reaches all nodes in the same cycle. The serial clock is the block clock: one bit per cycle.

A control word (bit 15 set) carries a 3-bit hop count in bits 13:11, a register select in bits 10:8 and a data byte in bits 7:0. The node claims a word whose hop count is zero; it writes or reads its own register. It lowers a non-zero hop count by one and sends the word on down the chain. Register 0 holds the operating mode in bits 1:0 (0 program, 1 data, 2 mixed, 3 behaves as program) and the chain length in bits 6:4.

In program mode every sample event produces one frame. In data and mixed modes an event produces one frame holding the node's own sample, then relays the words that arrive from upstream, to fill the chain length. Samples come from a stub input.

Top module: `cascade_node`

## Requirements
- R1: After reset the node is in program mode with chain length 1, so register 0 reads back as 0x10. The serial output and its frame sync stay low until the first word is due.
- R2: In program mode each sample event produces exactly one output frame, carrying 0x0000 unless a read reply is pending.
- R3: Every output frame is a one-cycle frame-sync pulse, followed in the next 16 cycles by the word, MSB first. The frame sync never rises while a word is being shifted out.
- R4: In program or mixed mode, a control word with a non-zero hop count is sent out as its own frame with bits 13:11 lowered by one and all other bits unchanged. It does not change register 0.
- R5: In program or mixed mode, a control word with bit 14 clear, hop count 0 and register select 0 loads the mode from data bits 1:0 and the chain length from data bits 6:4. Writes to other register selects have no effect.
- R6: A control word with bit 14 set and hop count 0 is a read request. The node's next sample-event frame for its own slot carries 0x00 in bits 15:8 and the selected register in bits 7:0 (register 0 as {0, length, 00, mode}; the other selects read 0x00).
- R7: In program mode, an input word with bit 15 clear produces no output and no register change.
- R8: In data or mixed mode each sample event produces one frame with the own-sample input. It then produces (length − 1) frames relaying upstream words in arrival order; a length of 0 counts as 1. Upstream words beyond the needed number are dropped.
- R9: In data mode nothing arriving on the serial input is decoded. A control word sent there leaves the mode and length unchanged and is not forwarded. When a relay slot is open, the word is passed on verbatim.
- R10: In mixed mode, input words with bit 15 set are decoded as in program mode, and words with bit 15 clear are relayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the serial bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_evt | input | 1 | One-cycle strobe marking a sample event |
| own_sample | input | 16 | Node's own converter sample (stub) |
| sdi | input | 1 | Serial data in, MSB first |
| sdi_fs | input | 1 | Input frame sync, one cycle before the MSB |
| sdo | output | 1 | Serial data out, MSB first |
| sdo_fs | output | 1 | Output frame sync, one cycle before the MSB |

## Verification
The bench builds the node with its default 16-bit word and a 3-bit chain length. This allows lengths 0 through 3 to be tried with upstream traffic that covers surplus words. The bench plays both the host and the upstream node. Random hop counts from 1 to 7 exercise forwarding, including words with the read bit set. Forward-versus-sample contention and back-to-back host words fall inside the single forward buffer's window.

// File: rtl/cnode_pkg.sv
package cnode_pkg;
  localparam int WORD_W   = 16;
  localparam int CTRL_BIT = 15;
  localparam int RD_BIT   = 14;
  localparam int HOP_LSB  = 11;
  localparam int HOP_W    = 3;
  localparam int SEL_LSB  = 8;
  localparam int SEL_W    = 3;
  localparam int DATA_W   = 8;
  localparam int LEN_W    = 3;
  localparam int LEFT_W   = LEN_W + 1;

  typedef enum logic [1:0] {
    MODE_PROG  = 2'd0,
    MODE_DATA  = 2'd1,
    MODE_MIXED = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  function automatic logic is_ctrl(input logic [WORD_W-1:0] w);
    return w[CTRL_BIT];
  endfunction

  function automatic logic [HOP_W-1:0] hop_of(input logic [WORD_W-1:0] w);
    return w[HOP_LSB +: HOP_W];
  endfunction

  function automatic logic [SEL_W-1:0] sel_of(input logic [WORD_W-1:0] w);
    return w[SEL_LSB +: SEL_W];
  endfunction

  function automatic logic [DATA_W-1:0] data_of(input logic [WORD_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  // lowers the hop field by one, leaving every other bit alone
  function automatic logic [WORD_W-1:0] hop_down(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[HOP_LSB +: HOP_W] = w[HOP_LSB +: HOP_W] - HOP_W'(1);
    return r;
  endfunction

  // frames per sample event in data or mixed mode
  function automatic logic [LEFT_W-1:0] frames_of(input logic [LEN_W-1:0] len);
    return (len == '0) ? LEFT_W'(1) : LEFT_W'(len);
  endfunction

  // readback image of register 0
  function automatic logic [DATA_W-1:0] cfg_image(input mode_e m, input logic [LEN_W-1:0] len);
    return {1'b0, len, 2'b00, m};
  endfunction
endpackage

// File: rtl/cnode_rx.sv
module cnode_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              sdi_fs,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o
);
  localparam int CW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh;
  logic [CW-1:0]     left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      left   <= '0;
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (sdi_fs) begin
        left <= CW'(WORD_W);
      end else if (left != '0) begin
        sh   <= {sh[WORD_W-2:0], sdi};
        left <= left - CW'(1);
        if (left == CW'(1)) begin
          word_o <= {sh[WORD_W-2:0], sdi};
          vld_o  <= 1'b1;
        end
      end
    end
  end

  // R3: a received word completes at most once per frame
  p_rx_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);
endmodule

// File: rtl/cnode_tx.sv
module cnode_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              sdo,
  output logic              sdo_fs
);
  localparam int CW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh;
  logic [CW-1:0]     left;
  logic              take;

  assign busy = sdo_fs || (left != '0);
  assign take = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      left   <= '0;
      sdo    <= 1'b0;
      sdo_fs <= 1'b0;
    end else begin
      sdo_fs <= take;
      if (take) begin
        sh   <= word;
        left <= CW'(WORD_W);
        sdo  <= 1'b0;
      end else if (left != '0) begin
        sdo  <= sh[WORD_W-1];
        sh   <= {sh[WORD_W-2:0], 1'b0};
        left <= left - CW'(1);
      end else begin
        sdo <= 1'b0;
      end
    end
  end

  p_fs_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_fs |=> !sdo_fs);
  p_bits_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_fs |=> (busy && !sdo_fs));
endmodule

// File: rtl/cnode_ctrl.sv
module cnode_ctrl
  import cnode_pkg::*;
#(
  parameter int WORD_W = cnode_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_evt,
  input  logic [WORD_W-1:0] own_sample,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_vld,
  input  logic              tx_busy,
  output logic              tx_start,
  output logic [WORD_W-1:0] tx_word
);
  mode_e             mode;
  logic [LEN_W-1:0]  len;
  logic [LEFT_W-1:0] evt_left;
  logic              first_pend;
  logic              fwd_vld, relay_vld, rd_pend;
  logic [WORD_W-1:0] fwd_word, relay_word;
  logic [SEL_W-1:0]  rd_sel;

  // named internal events
  logic is_prog, decode_on, ctl_word, own_hit, fwd_take, cfg_wr, rd_req;
  logic need_relay, relay_take;
  logic send_fwd, send_own, send_rel;
  logic load_fwd, load_own, load_rel;
  logic [DATA_W-1:0] rd_val;
  logic [WORD_W-1:0] own_word;

  always_comb begin
    is_prog    = (mode == MODE_PROG) || (mode == MODE_RSVD);
    decode_on  = (mode != MODE_DATA);
    ctl_word   = rx_vld && decode_on && is_ctrl(rx_word);
    own_hit    = ctl_word && (hop_of(rx_word) == '0);
    fwd_take   = ctl_word && (hop_of(rx_word) != '0);
    cfg_wr     = own_hit && !rx_word[RD_BIT] && (sel_of(rx_word) == '0);
    rd_req     = own_hit && rx_word[RD_BIT];
    need_relay = evt_left > LEFT_W'(first_pend);
    relay_take = rx_vld && !is_prog && !ctl_word && need_relay && !relay_vld && !sample_evt;

    send_fwd = fwd_vld;
    send_own = !fwd_vld && (evt_left != '0) && first_pend;
    send_rel = !fwd_vld && (evt_left != '0) && !first_pend && relay_vld;
    tx_start = !tx_busy && (send_fwd || send_own || send_rel);
    load_fwd = tx_start && send_fwd;
    load_own = tx_start && send_own;
    load_rel = tx_start && send_rel;

    rd_val   = (rd_sel == '0) ? cfg_image(mode, len) : '0;
    own_word = rd_pend ? {{(WORD_W-DATA_W){1'b0}}, rd_val}
             : (is_prog ? '0 : own_sample);

    if (send_fwd)      tx_word = fwd_word;
    else if (send_own) tx_word = own_word;
    else               tx_word = relay_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= MODE_PROG;
      len        <= LEN_W'(1);
      evt_left   <= '0;
      first_pend <= 1'b0;
      fwd_vld    <= 1'b0;
      fwd_word   <= '0;
      relay_vld  <= 1'b0;
      relay_word <= '0;
      rd_pend    <= 1'b0;
      rd_sel     <= '0;
    end else begin
      if (cfg_wr) begin
        mode <= mode_e'(rx_word[1:0]);
        len  <= rx_word[4 +: LEN_W];
      end

      if (fwd_take) begin
        fwd_vld  <= 1'b1;
        fwd_word <= hop_down(rx_word);
      end else if (load_fwd) begin
        fwd_vld <= 1'b0;
      end

      if (sample_evt) begin
        evt_left   <= is_prog ? LEFT_W'(1) : frames_of(len);
        first_pend <= 1'b1;
      end else if (load_own) begin
        evt_left   <= evt_left - LEFT_W'(1);
        first_pend <= 1'b0;
      end else if (load_rel) begin
        evt_left <= evt_left - LEFT_W'(1);
      end

      if (sample_evt) begin
        relay_vld <= 1'b0;
      end else if (relay_take) begin
        relay_vld  <= 1'b1;
        relay_word <= rx_word;
      end else if (load_rel) begin
        relay_vld <= 1'b0;
      end

      if (rd_req) begin
        rd_pend <= 1'b1;
        rd_sel  <= sel_of(rx_word);
      end else if (load_own) begin
        rd_pend <= 1'b0;
      end
    end
  end

  // R4: a new forward never lands on an unsent one
  p_fwd_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_take |-> !fwd_vld);
  // R9: serial input cannot reconfigure a node in data mode
  p_data_keeps_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DATA && rx_vld) |=> (mode == MODE_DATA && $stable(len)));
  // R6: a read reply is used once
  p_rd_consumed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_own && !rd_req) |=> !rd_pend);
  // R8: a relay slot is only filled while a relay frame is owed
  p_relay_owed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    relay_vld |-> (evt_left != '0));
endmodule

// File: rtl/cascade_node.sv
module cascade_node #(
  parameter int WORD_W = cnode_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_evt,
  input  logic [WORD_W-1:0] own_sample,
  input  logic              sdi,
  input  logic              sdi_fs,
  output logic              sdo,
  output logic              sdo_fs
);
  logic [WORD_W-1:0] rx_word, tx_word;
  logic              rx_vld, tx_busy, tx_start;

  cnode_rx #(.WORD_W(WORD_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdi_fs(sdi_fs),
    .word_o(rx_word), .vld_o(rx_vld)
  );

  cnode_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt), .own_sample(own_sample),
    .rx_word(rx_word), .rx_vld(rx_vld), .tx_busy(tx_busy),
    .tx_start(tx_start), .tx_word(tx_word)
  );

  cnode_tx #(.WORD_W(WORD_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .word(tx_word),
    .busy(tx_busy), .sdo(sdo), .sdo_fs(sdo_fs)
  );
endmodule

// File: tb/cascade_node_tb.sv
module cascade_node_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_evt = 1'b0;
  logic [15:0] own_sample = 16'h0;
  logic        sdi = 1'b0;
  logic        sdi_fs = 1'b0;
  logic        sdo, sdo_fs;

  int n_chk = 0, n_bad = 0, frame_err = 0, bits_left = 0;
  logic prev_fs = 1'b0;
  logic [15:0] acc;
  logic [15:0] got[$];
  logic [15:0] exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  cascade_node dut_i (
    .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt), .own_sample(own_sample),
    .sdi(sdi), .sdi_fs(sdi_fs), .sdo(sdo), .sdo_fs(sdo_fs)
  );

  // output frame collector, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (bits_left > 0) begin
        acc = {acc[14:0], sdo};
        bits_left = bits_left - 1;
        if (bits_left == 0) got.push_back(acc);
      end
      if (sdo_fs) begin
        if (bits_left != 0 || prev_fs) frame_err = frame_err + 1;
        bits_left = 16;
      end
      prev_fs = sdo_fs;
    end
  end

  function automatic logic [15:0] exp_fwd(input logic [15:0] w);
    return w - 16'h0800;
  endfunction

  function automatic logic [15:0] exp_cfg(input logic [1:0] m, input logic [2:0] l);
    return {8'h00, 1'b0, l, 2'b00, m};
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w);
    @(negedge clk); sdi_fs = 1'b1;
    @(negedge clk); sdi_fs = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      sdi = w[i];
      if (i != 0) @(negedge clk);
    end
    @(negedge clk); sdi = 1'b0;
  endtask

  task automatic pulse_evt(input logic [15:0] s);
    @(negedge clk); own_sample = s; sample_evt = 1'b1;
    @(negedge clk); sample_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    idle(60);
    chk(16'(got.size()), 16'(exp_q.size()), {tag, " frame count"});
    foreach (exp_q[i]) begin
      if (i < got.size()) chk(got[i], exp_q[i], tag);
    end
    got.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w, s, u1, u2, u3;
    void'($urandom(32'h5eed_0042));
    idle(3);
    // R1: quiet outputs in reset and after release
    chk({15'h0, sdo_fs}, 16'h0, "R1 fs in reset");
    chk({15'h0, sdo}, 16'h0, "R1 sdo in reset");
    rst_n = 1'b1;
    idle(30);
    chk(16'(got.size()), 16'h0, "R1 no frame before event");

    // R1/R6: reset register image
    send_word(16'hC000);
    pulse_evt(16'hABCD);
    exp_q.push_back(exp_cfg(2'd0, 3'd1));
    compare("R1 R6 reset readback");

    // R2: program events give one zero frame each
    for (int k = 0; k < 4; k++) begin
      pulse_evt(16'($urandom()));
      exp_q.push_back(16'h0000);
      compare("R2 program frame");
    end

    // R4: directed forward
    send_word(16'h8903);
    exp_q.push_back(16'h8103);
    compare("R4 forward");

    // R4: random forwards, including read bits
    for (int k = 0; k < 20; k++) begin
      w = 16'($urandom());
      w[15] = 1'b1;
      if (w[13:11] == 3'd0) w[13:11] = 3'd1 + 3'($urandom_range(0, 6));
      send_word(w);
      exp_q.push_back(exp_fwd(w));
      compare("R4 random forward");
    end

    // R4: forward contending with a sample frame
    fork
      pulse_evt(16'h1111);
      send_word(16'h9A5A);
    join
    exp_q.push_back(16'h0000);
    exp_q.push_back(exp_fwd(16'h9A5A));
    compare("R4 forward with event");

    // R4: back-to-back host forwards
    send_word(16'hB001);
    send_word(16'h8802);
    exp_q.push_back(16'hA801);
    exp_q.push_back(16'h8002);
    compare("R4 back to back");

    // R7: plain words are dropped in program mode
    send_word(16'h1234);
    send_word(16'h7FFF);
    compare("R7 plain word dropped");

    // R5: other register selects leave register 0 alone; R4 left it alone too
    send_word(16'h82FF);
    send_word(16'hC000);
    pulse_evt(16'h0);
    exp_q.push_back(exp_cfg(2'd0, 3'd1));
    compare("R5 other select no effect");
    send_word(16'hC300);
    pulse_evt(16'h0);
    exp_q.push_back(16'h0000);
    compare("R6 other select reads zero");

    // R5/R10: mixed mode, length 2
    send_word(16'h8022);
    s = 16'($urandom()); u1 = 16'($urandom()) & 16'h7FFF;
    fork
      pulse_evt(s);
      begin idle(2); send_word(u1); end
    join
    exp_q.push_back(s); exp_q.push_back(u1);
    compare("R10 mixed own then relay");

    // R6/R10: read in mixed mode replaces own slot
    send_word(16'hC000);
    u1 = 16'h0F0F;
    fork
      pulse_evt(16'h5555);
      begin idle(2); send_word(u1); end
    join
    exp_q.push_back(exp_cfg(2'd2, 3'd2)); exp_q.push_back(u1);
    compare("R6 R10 mixed readback");

    // R8: length 0 counts as one frame
    send_word(16'h8002);
    fork
      pulse_evt(16'h2468);
      begin idle(2); send_word(16'h0101); end
    join
    exp_q.push_back(16'h2468);
    compare("R8 length zero");

    // R5: switch to data mode with length 3
    send_word(16'h8031);
    for (int k = 0; k < 8; k++) begin
      s = 16'($urandom()); u1 = 16'($urandom()); u2 = 16'($urandom()); u3 = 16'($urandom());
      fork
        pulse_evt(s);
        begin idle(2); send_word(u1); send_word(u2); send_word(u3); end
      join
      exp_q.push_back(s); exp_q.push_back(u1); exp_q.push_back(u2);
      compare("R8 data own then relays");
    end

    // R9: control words in data mode are not decoded or forwarded
    send_word(16'h8001);
    send_word(16'h8903);
    compare("R9 idle control ignored");
    fork
      pulse_evt(16'h3C3C);
      begin idle(2); send_word(16'h8903); send_word(16'h8000); end
    join
    exp_q.push_back(16'h3C3C); exp_q.push_back(16'h8903); exp_q.push_back(16'h8000);
    compare("R9 control relayed verbatim");
    pulse_evt(16'h7777);
    exp_q.push_back(16'h7777);
    compare("R9 still data mode");
    // event with upstream relay resumes
    fork
      pulse_evt(16'h4242);
      begin idle(2); send_word(16'h0A0A); send_word(16'h0B0B); end
    join
    exp_q.push_back(16'h4242); exp_q.push_back(16'h0A0A); exp_q.push_back(16'h0B0B);
    compare("R8 R9 length kept");

    n_chk++;
    if (frame_err != 0) begin
      n_bad++;
      $display("FAIL R3 framing: actual %0d errors expected 0", frame_err);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule